// File: doc/BRIEF.md
# Two-Law Serial Clock Rate Generator

This block turns a fast module clock into the serial clock of a SPI-style shift engine. It outputs the serial clock level and a single-cycle toggle strobe that marks each clock edge. It takes a 13-bit rate word that holds two divisor fields and a law-select bit. The linear law divides by an even number, 2·(N+1). The exponential law divides by a power of two, 2^M. The serial clock always has equal high and low phases.

A write to the rate word goes into a pending stage first. It becomes active only while the clock is parked or at the rising edge that starts a new full period, so no shortened phase can appear. A parking input holds the serial clock low and clears the phase counter. After parking ends, the first rising edge therefore comes exactly one half-period later.

Top module: `sclk_rate_gen`

## Requirements
- R1: While reset is asserted and right after it, `sclk` and `sclk_tgl` are 0. The active rate word resets to linear law with N=0, so the first burst after reset has a half-period of 1 module-clock cycle.
- R2: Under the linear law (bit 12 = 1), the divisor N sits in bits 7:0. Each serial clock phase lasts N+1 module-clock cycles, so the period is 2·(N+1).
- R3: Under the exponential law (bit 12 = 0), the exponent M sits in bits 11:8. For M ≥ 1 each phase lasts 2^(M-1) cycles, so the period is 2^M.
- R4: An exponent of M = 0 cannot be realised as a pass-through. It is treated as divide-by-two, with a phase of 1 cycle.
- R5: The law not selected by bit 12 ignores its own field. Bits 11:8 have no effect under the linear law, and bits 7:0 have no effect under the exponential law.
- R6: While `hold` is 1, `sclk` is 0 from the next cycle on, and `sclk_tgl` stays 0.
- R7: After `hold` falls, `sclk` rises exactly one half-period later, counted in module-clock rising edges.
- R8: A rate word written while the clock runs leaves the phase in progress and the rest of its period unchanged. It takes effect from the next rising edge of `sclk`.
- R9: A rate word written while parked is the one used by the next burst.
- R10: The high phase and the low phase of every period are equal in length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | One-cycle write strobe for the rate word |
| cfg_wdata | input | 13 | Rate word: [7:0] linear N, [11:8] exponent M, [12] law select (1 = linear) |
| hold | input | 1 | Park request: holds sclk low and clears the phase counter |
| sclk | output | 1 | Serial clock level |
| sclk_tgl | output | 1 | Strobe, high in the cycle before each sclk edge |

## Verification
The assertions check several properties on every cycle. The phase counter never reaches the active half-period. Every toggle strobe flips the clock. Parking pins the clock low with a cleared counter. The active half-period changes only at a parking cycle or at a rising-edge boundary. Two kinds of behaviour need the bench's scenarios: the absolute phase lengths of both laws, and the exact delay of the first edge after parking. The bench sweeps every exponent, a range of linear divisors, and words with junk in the unused field. It also covers a rate change written in the middle of a high phase, where it measures the old phases running to completion and the new ones that follow.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

  typedef enum logic {
    LAW_EXP    = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  localparam int DEF_LIN_W = 8;
  localparam int DEF_EXP_W = 4;

endpackage

// File: rtl/sclkdiv_cfg.sv
module sclkdiv_cfg #(
  parameter int          CFG_W   = 13,
  parameter logic [12:0] RST_CFG = 13'h1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             apply,
  output logic [CFG_W-1:0] act
);

  logic [CFG_W-1:0] pend_q;
  logic             pend_v_q;
  logic             take;

  assign take = apply && pend_v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= CFG_W'(RST_CFG);
      pend_v_q <= 1'b0;
    end else if (wr) begin
      pend_q   <= wdata;
      pend_v_q <= 1'b1;
    end else if (take) begin
      pend_v_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    act <= CFG_W'(RST_CFG);
    else if (take) act <= pend_q;
  end

  AST_PENDING_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr) |=> !pend_v_q); // R9

  AST_ACT_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(act)); // R8

endmodule

// File: rtl/sclkdiv_law.sv
module sclkdiv_law
  import sclkdiv_pkg::*;
#(
  parameter int LIN_W = DEF_LIN_W,
  parameter int EXP_W = DEF_EXP_W,
  parameter int CW    = 15,
  localparam int CFG_W = LIN_W + EXP_W + 1
) (
  input  logic [CFG_W-1:0] act,
  output logic [CW-1:0]    half
);

  localparam int SEL_BIT = LIN_W + EXP_W;

  function automatic logic [CW-1:0] lin_half(input logic [LIN_W-1:0] n);
    return CW'(n) + CW'(1);
  endfunction

  function automatic logic [CW-1:0] exp_half(input logic [EXP_W-1:0] m);
    if (m == '0) return CW'(1);
    return CW'(1) << (m - EXP_W'(1));
  endfunction

  div_law_e         law;
  logic [LIN_W-1:0] n_fld;
  logic [EXP_W-1:0] m_fld;

  assign law   = div_law_e'(act[SEL_BIT]);
  assign n_fld = act[LIN_W-1:0];
  assign m_fld = act[SEL_BIT-1:LIN_W];

  always_comb begin
    unique case (law)
      LAW_LINEAR: half = lin_half(n_fld);
      default:    half = exp_half(m_fld);
    endcase
  end

  always_comb begin
    AST_HALF_NONZERO: assert (half != '0); // R4
  end

endmodule

// File: rtl/sclkdiv_count.sv
module sclkdiv_count #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [CW-1:0] half,
  output logic          tgl,
  output logic          sclk,
  output logic          rise_bound
);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end     = (cnt_q == half - CW'(1));
  assign tgl        = !hold && at_end;
  assign rise_bound = tgl && !sclk;

  always_ff @(posedge clk) begin
    if (!rst_n || hold) cnt_q <= '0;
    else if (at_end)    cnt_q <= '0;
    else                cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold) sclk <= 1'b0;
    else if (tgl)       sclk <= ~sclk;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half); // R2

  AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    tgl |=> (sclk != $past(sclk))); // R10

  AST_HOLD_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!sclk && cnt_q == '0)); // R6

  AST_FIRST_EDGE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (!sclk && cnt_q == '0)); // R7

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
  import sclkdiv_pkg::*;
#(
  parameter int LIN_W = DEF_LIN_W,
  parameter int EXP_W = DEF_EXP_W,
  localparam int CFG_W  = LIN_W + EXP_W + 1,
  localparam int CW_LIN = LIN_W + 1,
  localparam int CW_EXP = (1 << EXP_W) - 1,
  localparam int CW     = (CW_LIN > CW_EXP) ? CW_LIN : CW_EXP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             hold,
  output logic             sclk,
  output logic             sclk_tgl
);

  localparam logic [12:0] RST_WORD = 13'(1 << (LIN_W + EXP_W));

  logic [CFG_W-1:0] act_cfg;
  logic [CW-1:0]    cur_half;
  logic             rise_bound;
  logic             cfg_apply;

  assign cfg_apply = hold || rise_bound;

  sclkdiv_cfg #(.CFG_W(CFG_W), .RST_CFG(RST_WORD)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .apply (cfg_apply),
    .act   (act_cfg)
  );

  sclkdiv_law #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CW(CW)) u_law (
    .act  (act_cfg),
    .half (cur_half)
  );

  sclkdiv_count #(.CW(CW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .half       (cur_half),
    .tgl        (sclk_tgl),
    .sclk       (sclk),
    .rise_bound (rise_bound)
  );

  AST_HALF_MIDPERIOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !(sclk_tgl && !sclk)) |=> $stable(cur_half)); // R8

endmodule

// File: tb/test_sclk_rate_gen.sv
module test_sclk_rate_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [12:0] cfg_wdata = '0;
  logic        hold = 1'b1;
  logic        sclk;
  logic        sclk_tgl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sclk_rate_gen i_sclk_rate_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .hold(hold), .sclk(sclk), .sclk_tgl(sclk_tgl)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lin_expect(input int n);
    return n + 1;
  endfunction

  function automatic int exp_expect(input int m);
    return (m == 0) ? 1 : (2 ** m) / 2;
  endfunction

  task automatic write_word(input logic [12:0] w);
    cfg_wdata = w;
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic phase_len(input logic lvl, output int k);
    k = 0;
    while (sclk == lvl && k < 70000) begin
      k++;
      @(negedge clk);
    end
  endtask

  task automatic first_edge(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sclk && n < 70000);
  endtask

  // park, load a word, run one period and measure it
  task automatic run_word(input logic [12:0] w, input int exp_half, input string tag);
    int n, hi, lo;
    hold = 1'b1;
    @(negedge clk);
    write_word(w);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!sclk && !sclk_tgl, "R6 parked", sclk, 0);
    end
    hold = 1'b0;
    first_edge(n);
    check(n == exp_half, {"R7 first edge ", tag}, n, exp_half);
    phase_len(1'b1, hi);
    phase_len(1'b0, lo);
    check(hi == exp_half, {"R9 high ", tag}, hi, exp_half);
    check(lo == hi, "R10 duty", lo, hi);
    hold = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int n, hi, lo, k;
    repeat (3) @(negedge clk);
    check(!sclk && !sclk_tgl, "R1 in reset", sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sclk && !sclk_tgl, "R1 after reset", sclk, 0);
    // R1: default word, no write
    hold = 1'b0;
    first_edge(n);
    check(n == 1, "R1 default half", n, 1);
    phase_len(1'b1, hi);
    check(hi == 1, "R1 default high", hi, 1);
    hold = 1'b1;
    @(negedge clk);

    // R2: linear sweep
    for (int v = 0; v < 24; v++)
      run_word({1'b1, 4'h0, 8'(v)}, lin_expect(v), "R2 linear");
    run_word({1'b1, 4'h0, 8'd255}, lin_expect(255), "R2 linear max");

    // R3 / R4: every exponent
    for (int m = 0; m < 16; m++)
      run_word({1'b0, 4'(m), 8'h00}, exp_expect(m), (m == 0) ? "R4 exp zero" : "R3 exp");

    // R5: unused field ignored
    run_word({1'b1, 4'hF, 8'd5}, 6, "R5 linear junk");
    run_word({1'b0, 4'd3, 8'hFF}, 4, "R5 exp junk");

    // R8: change while running, mid high phase
    run_word({1'b1, 4'h0, 8'd3}, 4, "R8 setup");
    hold = 1'b0;
    first_edge(n);
    write_word({1'b1, 4'h0, 8'd9});
    phase_len(1'b1, k);
    check(k + 1 == 4, "R8 old high kept", k + 1, 4);
    phase_len(1'b0, lo);
    check(lo == 4, "R8 old low kept", lo, 4);
    phase_len(1'b1, hi);
    check(hi == 10, "R8 new high", hi, 10);
    phase_len(1'b0, lo);
    check(lo == 10, "R8 new low", lo, 10);
    hold = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!sclk, "R6 repark", sclk, 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule